// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the configuration front end of a converter-style chip. A host drives three wires: an active-low enable, a serial clock and a serial data line. Every 16 bits shifted in while the enable is low form one word: an 8-bit address followed by 8 data bits, both most significant bit first. On the last bit of each word the data byte is written into a small bank of configuration registers, whose contents are presented in parallel on `cfg_q` for the rest of the chip. Several words may follow each other in one enable window. A word that is still incomplete when the enable rises is thrown away.

The serial pins are asynchronous to the block. A two-flop synchronizer brings the enable, clock and data onto the system clock. A framing state machine with states ST_IDLE, ST_ADDR and ST_DATA then counts the serial clock falling edges. The transitions are: ST_IDLE to ST_ADDR when the enable goes low; ST_ADDR to ST_DATA on the eighth falling edge; ST_DATA back to ST_ADDR on the sixteenth falling edge, which also commits the write; any state to ST_IDLE when the enable goes high, which also clears the bit counter.

Register 0 holds two control bits. Bit 0 selects readback mode. While it is set, writes to every other address are refused, and the shared output pin `sdout` shifts out the addressed register during the data half of each word, MSB first. While it is clear, `sdout` simply mirrors the over-range flag `ovr_in`. Bit 1 is a self-clearing software reset that returns the whole bank to 0x00.

Top module: `serreg_top`

## Requirements
- R1: Serial clock falling edges are counted only while the synchronized enable is low; clock activity with the enable high changes no register and leaves no partial count behind.
- R2: Each group of 16 falling edges is one word. The first 8 bits are the address and the next 8 are the data, each MSB first. The data lands in the addressed register when the 16th bit is taken.
- R3: Back-to-back words in one enable window are each written. Bits after the last complete word of a window cause no write.
- R4: Raising the enable returns the framer to its idle state and clears the bit counter, so the next window begins a new address phase.
- R5: The hardware reset input, while high, sets every register to 0x00, which makes `sdout` follow `ovr_in`.
- R6: Writing 1 to bit 0 of address 0 enters readback mode. In that mode, writes to any address other than 0 are refused. Writing 0 to that bit leaves the mode.
- R7: In readback mode, `sdout` is 0 while idle and during the address phase. During the 8 data-bit periods of a word it carries bits 7 down to 0 of the addressed register, valid before each serial clock falling edge.
- R8: In readback mode, reading address 0 or an address with no register returns 0x00.
- R9: Outside readback mode, `sdout` equals `ovr_in`.
- R10: Writing a byte with bit 1 set to address 0 clears every register to 0x00, including bit 0 of address 0. Bit 1 of register 0 never holds a 1.
- R11: A write to an address at or above NREG (default 8) changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Hardware reset, active high, asynchronous |
| sen_n | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| ovr_in | input | 1 | Over-range flag from the converter path |
| sdout | output | 1 | Shared pin: over-range flag, or register data in readback mode |
| cfg_q | output | NREG*8 | Register bank contents; register i is bits [8i+7:8i] |

## Verification
The bench sweeps every register and a stepped range of data values, and reads each one back through the shared pin. A design with the address and data halves swapped, or with the wrong bit order, would return wrong bytes. The bench sends a partial word followed by a new window, and a full word followed by leftover bits. A counter that is not cleared would misalign the next word, and a missing drop would corrupt a register. It also writes while readback mode is on, reads address 0 and an out-of-range address, and issues a software reset from both modes. A broken lockout, a leaking read mux or a reset that leaves the mode bit set each show up as a mismatched byte or a wrong `sdout` level. Finally, the bench toggles the clock with the enable high. A framer that counts such edges would shift every later word.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } frame_state_e;

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/serreg_framer.sv
module serreg_framer
    import serreg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int CW = $clog2(AW + DW),
    localparam int SW = (AW > DW) ? AW : DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sen_n_q,
    input  logic          sclk_q,
    input  logic          sdin_q,
    output frame_state_e  state_o,
    output logic [CW-1:0] cnt_o,
    output logic          wr_en_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wr_data_o
);

    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] WORD_LAST = CW'(AW + DW - 1);

    frame_state_e  state, nxt;
    logic [CW-1:0] cnt;
    logic [SW-1:0] sh;
    logic [AW-1:0] addr_q;
    logic          sclk_prev;
    logic          fall;

    // a falling edge only counts inside an enable-low window
    assign fall = sclk_prev & ~sclk_q & ~sen_n_q;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!sen_n_q) nxt = ST_ADDR;
            ST_ADDR: begin
                if (sen_n_q)                        nxt = ST_IDLE;
                else if (fall && cnt == ADDR_LAST)  nxt = ST_DATA;
            end
            ST_DATA: begin
                if (sen_n_q)                        nxt = ST_IDLE;
                else if (fall && cnt == WORD_LAST)  nxt = ST_ADDR;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // bit counter, shifter and address capture
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt       <= '0;
            sh        <= '0;
            addr_q    <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_q;
            if (sen_n_q) begin
                cnt <= '0;
            end else if (fall) begin
                sh  <= {sh[SW-2:0], sdin_q};
                cnt <= (cnt == WORD_LAST) ? '0 : cnt + 1'b1;
                if (cnt == ADDR_LAST) begin
                    addr_q <= {sh[AW-2:0], sdin_q};
                end
            end
        end
    end

    // outputs
    always_comb begin
        state_o   = state;
        cnt_o     = cnt;
        addr_o    = addr_q;
        wr_data_o = {sh[DW-2:0], sdin_q};
        wr_en_o   = (state == ST_DATA) && fall && (cnt == WORD_LAST);
    end

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
    parameter int NREG   = 8,
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int RD_BIT = 0,
    parameter int SR_BIT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [NREG*DW-1:0] cfg_q,
    output logic [DW-1:0]      rd_byte,
    output logic               readout_o
);

    logic soft_clr;

    assign soft_clr  = wr_en && (wr_addr == '0) && wr_data[SR_BIT];
    assign readout_o = cfg_q[RD_BIT];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        logic          hit;

        assign hit = wr_en && (wr_addr == AW'(g)) && ((g == 0) || !readout_o);

        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                q <= '0;
            end else if (soft_clr) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_data;
            end
        end

        assign cfg_q[g*DW +: DW] = q;
    end

    // address 0 and unmapped addresses read as zero
    always_comb begin
        rd_byte = '0;
        for (int i = 1; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_byte = cfg_q[i*DW +: DW];
        end
    end

endmodule

// File: rtl/serreg_top.sv
module serreg_top
    import serreg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sen_n,
    input  logic               sclk,
    input  logic               sdin,
    input  logic               ovr_in,
    output logic               sdout,
    output logic [NREG*DW-1:0] cfg_q
);

    localparam int CW = $clog2(AW + DW);
    localparam logic [CW-1:0] WORD_LAST = CW'(AW + DW - 1);

    logic [2:0]    pins_q;
    logic          sen_n_q, sclk_q, sdin_q;
    frame_state_e  state;
    logic [CW-1:0] cnt;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_byte;
    logic          readout;
    logic [CW-1:0] remain;
    logic          data_bit;

    serreg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sdin, sclk, sen_n}),
        .sync_o  (pins_q)
    );

    assign sen_n_q = pins_q[0];
    assign sclk_q  = pins_q[1];
    assign sdin_q  = pins_q[2];

    serreg_framer #(.AW(AW), .DW(DW)) i_framer (
        .clk       (clk),
        .rst       (rst),
        .sen_n_q   (sen_n_q),
        .sclk_q    (sclk_q),
        .sdin_q    (sdin_q),
        .state_o   (state),
        .cnt_o     (cnt),
        .wr_en_o   (wr_en),
        .addr_o    (addr),
        .wr_data_o (wr_data)
    );

    serreg_bank #(.NREG(NREG), .AW(AW), .DW(DW)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (addr),
        .wr_data   (wr_data),
        .rd_addr   (addr),
        .cfg_q     (cfg_q),
        .rd_byte   (rd_byte),
        .readout_o (readout)
    );

    // bits still to come in the word select the readback bit, MSB first
    assign remain = WORD_LAST - cnt;

    always_comb begin
        data_bit = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (remain == CW'(i)) data_bit = rd_byte[i];
        end
    end

    // shared output pin
    always_comb begin
        if (!readout)               sdout = ovr_in;
        else if (state == ST_DATA)  sdout = data_bit;
        else                        sdout = 1'b0;
    end

endmodule

// File: rtl/serreg_chk.sv
module serreg_chk
    import serreg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int CW   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               sen_q,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic [DW-1:0]      wr_data,
    input logic               readout,
    input frame_state_e       state,
    input logic [CW-1:0]      cnt,
    input logic               sdout,
    input logic [NREG*DW-1:0] cfg_q
);

    localparam logic [AW-1:0] NREG_A = AW'(NREG);

    logic          pend;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pend   <= 1'b0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            pend   <= wr_en && !readout && (wr_addr != '0) && (wr_addr < NREG_A);
            p_addr <= wr_addr;
            p_data <= wr_data;
        end
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        pend |-> (cfg_q[int'(p_addr)*DW +: DW] == p_data));

    // R1
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !sen_q);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        sen_q |=> (cnt == '0));

    // R6
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && readout && (wr_addr != '0)) |=> $stable(cfg_q));

    // R7
    addr_phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (readout && (state != ST_DATA)) |-> !sdout);

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == '0) && wr_data[1]) |=> (cfg_q == '0));

endmodule

bind serreg_top serreg_chk #(.NREG(NREG), .AW(AW), .DW(DW), .CW(CW)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .sen_q   (sen_n_q),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (wr_data),
    .readout (readout),
    .state   (state),
    .cnt     (cnt),
    .sdout   (sdout),
    .cfg_q   (cfg_q)
);

// File: tb/test_serreg_top.sv
module test_serreg_top;

    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sen_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        ovr_in = 1'b0;
    logic        sdout;
    logic [63:0] cfg_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];

    always #2 clk = ~clk;

    serreg_top #(.NREG(NREG), .AW(8), .DW(8)) i_serreg_top (
        .clk    (clk),
        .rst    (rst),
        .sen_n  (sen_n),
        .sclk   (sclk),
        .sdin   (sdin),
        .ovr_in (ovr_in),
        .sdout  (sdout),
        .cfg_q  (cfg_q)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic bank_check(input string tag);
        for (int i = 0; i < NREG; i++)
            check8($sformatf("%s reg%0d", tag, i), cfg_q[i*8 +: 8], mdl[i]);
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    endtask

    task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00) begin
            if (d[1]) mdl_clear();
            else      mdl[0] = d;
        end else if (!mdl[0][0] && a < NREG) begin
            mdl[a[2:0]] = d;
        end
    endtask

    task automatic open_win();
        sen_n = 1'b0;
        tick(6);
    endtask

    task automatic close_win();
        tick(2);
        sen_n = 1'b1;
        tick(8);
    endtask

    task automatic bit_out(input logic b, output logic o);
        sdin = b;
        sclk = 1'b1;
        tick(4);
        o = sdout;
        sclk = 1'b0;
        tick(4);
    endtask

    task automatic send_word(input logic [7:0] a, input logic [7:0] d);
        logic o;
        for (int i = 7; i >= 0; i--) bit_out(a[i], o);
        for (int i = 7; i >= 0; i--) bit_out(d[i], o);
        mdl_write(a, d);
    endtask

    task automatic read_word(input logic [7:0] a, input logic [7:0] d,
                             input string tag, output logic [7:0] got);
        logic o;
        for (int i = 7; i >= 0; i--) begin
            bit_out(a[i], o);
            check1($sformatf("R7 %s address-phase bit %0d", tag, i), o, 1'b0);
        end
        for (int i = 7; i >= 0; i--) begin
            bit_out(d[i], o);
            got[i] = o;
        end
        mdl_write(a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic o;
        mdl_clear();
        tick(4);
        rst = 1'b0;
        tick(4);

        // R5 reset state, R9 pass-through
        bank_check("R5 after reset");
        ovr_in = 1'b1; tick(1);
        check1("R9 ovr high", sdout, 1'b1);
        ovr_in = 1'b0; tick(1);
        check1("R9 ovr low", sdout, 1'b0);

        // R2 one word per window, every register
        for (int a = 1; a < NREG; a++) begin
            open_win();
            send_word(8'(a), 8'((a * 37 + 11) & 255));
            close_win();
        end
        bank_check("R2 single-word sweep");

        // R3 back-to-back words in one window
        open_win();
        for (int a = 1; a < NREG; a++) send_word(8'(a), 8'((a * 91 + 3) & 255));
        close_win();
        bank_check("R3 multi-word window");

        // R3 trailing partial word dropped
        open_win();
        send_word(8'h02, 8'h5A);
        for (int i = 0; i < 10; i++) bit_out(1'b1, o);
        close_win();
        bank_check("R3 trailing bits");

        // R4 partial window then a fresh window
        open_win();
        for (int i = 0; i < 7; i++) bit_out(1'b1, o);
        close_win();
        open_win();
        send_word(8'h04, 8'h3C);
        close_win();
        bank_check("R4 restart after partial");

        // R1 clock activity with enable high
        for (int i = 0; i < 20; i++) begin
            sdin = i[0];
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(4);
        end
        bank_check("R1 enable high clocks");
        open_win();
        send_word(8'h06, 8'hA5);
        close_win();
        bank_check("R1 word after idle clocks");

        // R11 unmapped addresses
        open_win();
        send_word(8'h08, 8'hC3);
        send_word(8'h83, 8'h77);
        close_win();
        bank_check("R11 unmapped writes");

        // R6 enter readback, R7 read every register
        open_win();
        send_word(8'h00, 8'h01);
        close_win();
        check1("R6 readback bit set", cfg_q[0], 1'b1);
        ovr_in = 1'b1; tick(1);
        check1("R7 idle output zero", sdout, 1'b0);
        for (int a = 1; a < NREG; a++) begin
            open_win();
            read_word(8'(a), 8'hFF, $sformatf("read %0d", a), got);
            close_win();
            check8($sformatf("R7 readback reg%0d", a), got, mdl[a]);
        end
        bank_check("R6 reads blocked as writes");

        // R8 address 0 and unmapped address read zero
        open_win();
        read_word(8'h00, 8'h01, "read 0", got);
        close_win();
        check8("R8 read address 0", got, 8'h00);
        open_win();
        read_word(8'h09, 8'h00, "read 9", got);
        close_win();
        check8("R8 read address 9", got, 8'h00);

        // R6 write refused in readback
        open_win();
        send_word(8'h01, 8'h99);
        close_win();
        bank_check("R6 lockout");

        // R6 exit, R9 pass-through returns
        open_win();
        send_word(8'h00, 8'h00);
        close_win();
        check1("R6 readback bit clear", cfg_q[0], 1'b0);
        tick(1);
        check1("R9 ovr after exit", sdout, 1'b1);
        ovr_in = 1'b0; tick(1);
        check1("R9 ovr low after exit", sdout, 1'b0);

        // R2 R7 data sweep on one register through the pin
        for (int v = 0; v < 256; v += 5) begin
            open_win();
            send_word(8'h05, 8'(v));
            send_word(8'h00, 8'h01);
            read_word(8'h05, 8'h00, "sweep", got);
            send_word(8'h00, 8'h00);
            close_win();
            check8($sformatf("R7 sweep value %0d", v), got, 8'(v));
        end
        bank_check("R2 after sweep");

        // R10 software reset from normal mode
        open_win();
        send_word(8'h03, 8'hEE);
        send_word(8'h00, 8'h02);
        close_win();
        bank_check("R10 soft reset");

        // R10 software reset from readback mode
        open_win();
        send_word(8'h07, 8'h42);
        send_word(8'h00, 8'h01);
        send_word(8'h00, 8'h03);
        close_win();
        bank_check("R10 soft reset in readback");
        ovr_in = 1'b1; tick(1);
        check1("R10 readback left after soft reset", sdout, 1'b1);
        ovr_in = 1'b0;

        // R5 hardware reset clears a loaded bank
        open_win();
        send_word(8'h01, 8'h11);
        send_word(8'h00, 8'h01);
        close_win();
        bank_check("R5 before hw reset");
        rst = 1'b1; tick(2);
        rst = 1'b0; tick(2);
        mdl_clear();
        bank_check("R5 after hw reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule